// File: doc/BRIEF.md
# Eight-Pin I/O Port Controller with Dual Peripheral Mux

The block controls one eight-pin general-purpose I/O port. Software writes and reads six configuration registers over a simple synchronous bus: output data, direction, peripheral enable, peripheral choice, slew rate and pull-up. A seventh, read-only address returns the pin levels after a two-flop synchronizer. For each pin, the block drives an output value, an output enable, a fast-slew flag and a pull-up enable toward the pad.

Each pin is configured on its own. When a pin's peripheral-enable bit is clear, the pin is plain GPIO, and its output value and enable come from the data and direction registers. When the bit is set, the pin's choice bit picks one of two peripherals, A or B, and that peripheral's output and output-enable signals drive the pad. The slew and pull-up bits reach the pad in either mode. An open-drain line is built by leaving the data bit at 0 and toggling the direction bit, with the pull-up holding the line high while the driver is off.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset, every configuration register reads 0. As a result, pad_oe, pad_fast and pad_pullup are all 0.
- R2: Registers are mapped as follows: data 0, direction 1, peripheral enable 2, peripheral choice 3, slew 4, pull-up 5. A write at the clock edge where bus_we is 1 updates the register, and the new value reads back on bus_rdata combinationally from bus_addr. With bus_we at 0, no register changes. Address 7 reads 0.
- R3: For a pin whose peripheral-enable bit is 0, pad_out equals its data bit and pad_oe equals its direction bit, whatever its peripheral-choice bit is.
- R4: For a pin with peripheral enable 1 and choice 0, pad_out and pad_oe follow periph_a_out and periph_a_oe.
- R5: For a pin with peripheral enable 1 and choice 1, pad_out and pad_oe follow periph_b_out and periph_b_oe.
- R6: pad_fast equals the slew register (1 = fast, 0 = slow) in both GPIO and peripheral mode.
- R7: pad_pullup equals the pull-up register.
- R8: Address 6 returns pin_in delayed by two clock edges: a change on pin_in is not visible after one edge and is visible after two. Writes to address 6 change nothing.
- R9: With data bit 0, direction 1 gives pad_out 0 and pad_oe 1 (the line is driven low), and direction 0 gives pad_oe 0 (the driver is off).
- R10: Pins with different modes in the same port each follow only their own bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 8 | Raw pad input levels |
| periph_a_out | input | 8 | Peripheral A output values |
| periph_a_oe | input | 8 | Peripheral A output enables |
| periph_b_out | input | 8 | Peripheral B output values |
| periph_b_oe | input | 8 | Peripheral B output enables |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_fast | output | 8 | Fast-slew select per pin |
| pad_pullup | output | 8 | Weak pull-up enable per pin |

## Verification
The assertions check on every cycle that each pin's pad outputs follow the source its enable and choice bits name. They also check that slew and pull-up writes reach the pad one edge later, that registers hold when no write occurs, and that the input readback matches pin_in from two edges earlier. Only the bench scenarios can show the reset values as seen at the bus, the exact readback of every address, the open-drain sequence on a line, and a mixed port where neighbouring pins sit in different modes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_DOUT   = 3'd0,
        RA_DIR    = 3'd1,
        RA_ALTEN  = 3'd2,
        RA_ALTSEL = 3'd3,
        RA_FAST   = 3'd4,
        RA_PULL   = 3'd5,
        RA_PINS   = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic              we_i,
    input  logic [W-1:0]      pins_i,
    output logic [W-1:0]      rdata_o,
    output logic [W-1:0]      dout_o,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      alten_o,
    output logic [W-1:0]      altsel_o,
    output logic [W-1:0]      fast_o,
    output logic [W-1:0]      pull_o
);
    typedef struct packed {
        logic [W-1:0] dout;
        logic [W-1:0] dir;
        logic [W-1:0] alten;
        logic [W-1:0] altsel;
        logic [W-1:0] fast;
        logic [W-1:0] pull;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (addr_i)
                RA_DOUT:   cfg_d.dout   = wdata_i;
                RA_DIR:    cfg_d.dir    = wdata_i;
                RA_ALTEN:  cfg_d.alten  = wdata_i;
                RA_ALTSEL: cfg_d.altsel = wdata_i;
                RA_FAST:   cfg_d.fast   = wdata_i;
                RA_PULL:   cfg_d.pull   = wdata_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (addr_i)
            RA_DOUT:   rdata_o = cfg_q.dout;
            RA_DIR:    rdata_o = cfg_q.dir;
            RA_ALTEN:  rdata_o = cfg_q.alten;
            RA_ALTSEL: rdata_o = cfg_q.altsel;
            RA_FAST:   rdata_o = cfg_q.fast;
            RA_PULL:   rdata_o = cfg_q.pull;
            RA_PINS:   rdata_o = pins_i;
            default:   rdata_o = '0;
        endcase
    end

    assign dout_o   = cfg_q.dout;
    assign dir_o    = cfg_q.dir;
    assign alten_o  = cfg_q.alten;
    assign altsel_o = cfg_q.altsel;
    assign fast_o   = cfg_q.fast;
    assign pull_o   = cfg_q.pull;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] dout_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] alten_i,
    input  logic [W-1:0] altsel_i,
    input  logic [W-1:0] a_out_i,
    input  logic [W-1:0] a_oe_i,
    input  logic [W-1:0] b_out_i,
    input  logic [W-1:0] b_oe_i,
    output logic [W-1:0] out_o,
    output logic [W-1:0] oe_o
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        logic per_out, per_oe;
        always_comb begin
            per_out = altsel_i[p] ? b_out_i[p] : a_out_i[p];
            per_oe  = altsel_i[p] ? b_oe_i[p]  : a_oe_i[p];
            out_o[p] = alten_i[p] ? per_out : dout_i[p];
            oe_o[p]  = alten_i[p] ? per_oe  : dir_i[p];
        end
    end
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
    import gpio_port_pkg::*;
#(
    parameter int NPINS = PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  periph_a_out,
    input  logic [NPINS-1:0]  periph_a_oe,
    input  logic [NPINS-1:0]  periph_b_out,
    input  logic [NPINS-1:0]  periph_b_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_fast,
    output logic [NPINS-1:0]  pad_pullup
);
    logic [NPINS-1:0] cfg_dout, cfg_dir, cfg_alten, cfg_altsel;
    logic [NPINS-1:0] cfg_fast, cfg_pull, pin_sync;

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(pin_in), .sync_o(pin_sync)
    );

    gpio_regfile #(.W(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .we_i(bus_we), .pins_i(pin_sync), .rdata_o(bus_rdata),
        .dout_o(cfg_dout), .dir_o(cfg_dir), .alten_o(cfg_alten),
        .altsel_o(cfg_altsel), .fast_o(cfg_fast), .pull_o(cfg_pull)
    );

    gpio_pin_mux #(.W(NPINS)) u_mux (
        .dout_i(cfg_dout), .dir_i(cfg_dir), .alten_i(cfg_alten),
        .altsel_i(cfg_altsel), .a_out_i(periph_a_out), .a_oe_i(periph_a_oe),
        .b_out_i(periph_b_out), .b_oe_i(periph_b_oe),
        .out_o(pad_out), .oe_o(pad_oe)
    );

    assign pad_fast   = cfg_fast;
    assign pad_pullup = cfg_pull;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NPINS = PORT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic              bus_we,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  periph_a_out,
    input logic [NPINS-1:0]  periph_a_oe,
    input logic [NPINS-1:0]  periph_b_out,
    input logic [NPINS-1:0]  periph_b_oe,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_fast,
    input logic [NPINS-1:0]  pad_pullup,
    input logic [NPINS-1:0]  cfg_dout,
    input logic [NPINS-1:0]  cfg_dir,
    input logic [NPINS-1:0]  cfg_alten,
    input logic [NPINS-1:0]  cfg_altsel
);
    logic [1:0] live_edges;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 live_edges <= '0;
        else if (live_edges != 2'd3) live_edges <= live_edges + 2'd1;
    end

    // R1: leaving reset, pads are undriven, slow and without pull-up
    a_r1_reset_pads: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0 && pad_fast == '0 && pad_pullup == '0));

    // R2: registers hold without a write strobe
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(cfg_dout) && $stable(cfg_dir)
                     && $stable(cfg_alten) && $stable(cfg_altsel)));

    // R3: GPIO pins follow data and direction registers
    a_r3_gpio_path: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ cfg_dout) | (pad_oe ^ cfg_dir)) & ~cfg_alten) == '0);

    // R4: peripheral A path
    a_r4_func_a: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ periph_a_out) | (pad_oe ^ periph_a_oe))
         & cfg_alten & ~cfg_altsel) == '0);

    // R5: peripheral B path
    a_r5_func_b: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ periph_b_out) | (pad_oe ^ periph_b_oe))
         & cfg_alten & cfg_altsel) == '0);

    // R6: slew write reaches pad one edge later
    a_r6_slew_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RA_FAST) |=> pad_fast == $past(bus_wdata));

    // R7: pull-up write reaches pad one edge later
    a_r7_pull_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RA_PULL) |=> pad_pullup == $past(bus_wdata));

    // R8: input readback lags pin_in by two edges
    a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (live_edges >= 2'd2 && bus_addr == RA_PINS) |-> bus_rdata == $past(pin_in, 2));
endmodule

bind gpio_port_mux gpio_port_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .periph_a_out(periph_a_out), .periph_a_oe(periph_a_oe),
    .periph_b_out(periph_b_out), .periph_b_oe(periph_b_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_fast(pad_fast),
    .pad_pullup(pad_pullup), .cfg_dout(cfg_dout), .cfg_dir(cfg_dir),
    .cfg_alten(cfg_alten), .cfg_altsel(cfg_altsel)
);

// File: tb/gpio_port_mux_tb.sv
module gpio_port_mux_tb;
    localparam int SEL_RD = 0, SEL_OUT = 1, SEL_OE = 2, SEL_FAST = 3, SEL_PULL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] a_out = '0, a_oe = '0, b_out = '0, b_oe = '0;
    logic [7:0] pad_out, pad_oe, pad_fast, pad_pullup;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    gpio_port_mux u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .periph_a_out(a_out), .periph_a_oe(a_oe),
        .periph_b_out(b_out), .periph_b_oe(b_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_fast(pad_fast),
        .pad_pullup(pad_pullup)
    );

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.sel)
                SEL_RD:   act = bus_rdata;
                SEL_OUT:  act = pad_out;
                SEL_OE:   act = pad_oe;
                SEL_FAST: act = pad_fast;
                default:  act = pad_pullup;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    task automatic push(input int sel, input logic [7:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        push(SEL_RD, e, tag);
    endtask

    task automatic exp_pad(input int sel, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        push(sel, e, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a < 6; a++) exp_rd(3'(a), 8'h00, "R1 reg reset");
        exp_pad(SEL_OE, 8'h00, "R1 oe reset");
        exp_pad(SEL_FAST, 8'h00, "R1 fast reset");
        exp_pad(SEL_PULL, 8'h00, "R1 pull reset");

        // R2 write/readback
        wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h00);
        wr(3'd3, 8'h44); wr(3'd4, 8'h55); wr(3'd5, 8'h66);
        exp_rd(3'd0, 8'h11, "R2 dout rb");
        exp_rd(3'd1, 8'h22, "R2 dir rb");
        exp_rd(3'd3, 8'h44, "R2 altsel rb");
        exp_rd(3'd4, 8'h55, "R2 fast rb");
        exp_rd(3'd5, 8'h66, "R2 pull rb");
        exp_rd(3'd7, 8'h00, "R2 unused addr");
        @(posedge clk); #1;
        bus_addr = 3'd0; bus_wdata = 8'hFF; bus_we = 1'b0;
        @(posedge clk); #1;
        push(SEL_RD, 8'h11, "R2 no write without strobe");

        // R3 GPIO mode ignores altsel (altsel=44)
        wr(3'd0, 8'hC3); wr(3'd1, 8'h5A);
        a_out = 8'hFF; a_oe = 8'hFF; b_out = 8'hFF; b_oe = 8'hFF;
        exp_pad(SEL_OUT, 8'hC3, "R3 gpio out");
        exp_pad(SEL_OE, 8'h5A, "R3 gpio oe");

        // R6/R7 pad flags in GPIO mode
        wr(3'd4, 8'hA0); wr(3'd5, 8'h0C);
        exp_pad(SEL_FAST, 8'hA0, "R6 fast gpio");
        exp_pad(SEL_PULL, 8'h0C, "R7 pull");

        // R4 all pins peripheral A
        a_out = 8'h96; a_oe = 8'h3E; b_out = 8'h00; b_oe = 8'h00;
        wr(3'd3, 8'h00); wr(3'd2, 8'hFF);
        exp_pad(SEL_OUT, 8'h96, "R4 func A out");
        exp_pad(SEL_OE, 8'h3E, "R4 func A oe");
        exp_pad(SEL_FAST, 8'hA0, "R6 fast alt mode");

        // R5 all pins peripheral B
        b_out = 8'h69; b_oe = 8'hC1;
        wr(3'd3, 8'hFF);
        exp_pad(SEL_OUT, 8'h69, "R5 func B out");
        exp_pad(SEL_OE, 8'hC1, "R5 func B oe");

        // R10 mixed port
        wr(3'd2, 8'hF0); wr(3'd3, 8'hCC); wr(3'd0, 8'hA5); wr(3'd1, 8'h3C);
        a_out = 8'h5A; a_oe = 8'hFF; b_out = 8'h33; b_oe = 8'h00;
        exp_pad(SEL_OUT, 8'h15, "R10 mixed out");
        exp_pad(SEL_OE, 8'h3C, "R10 mixed oe");

        // R9 open drain on all pins
        wr(3'd2, 8'h00); wr(3'd0, 8'h00); wr(3'd5, 8'hFF); wr(3'd1, 8'hFF);
        exp_pad(SEL_OUT, 8'h00, "R9 driven low out");
        exp_pad(SEL_OE, 8'hFF, "R9 driven low oe");
        wr(3'd1, 8'h00);
        exp_pad(SEL_OE, 8'h00, "R9 released oe");
        exp_pad(SEL_PULL, 8'hFF, "R9 pull while released");

        // R8 two-edge synchronizer
        @(posedge clk); #1;
        bus_addr = 3'd6; pin_in = 8'hB7;
        @(posedge clk); #1;
        push(SEL_RD, 8'h00, "R8 not visible after one edge");
        @(posedge clk); #1;
        push(SEL_RD, 8'hB7, "R8 visible after two edges");
        wr(3'd6, 8'h00);
        exp_rd(3'd6, 8'hB7, "R8 write to input addr ignored");
        exp_rd(3'd0, 8'h00, "R8 write to input addr touched no reg");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule